// File: doc/BRIEF.md
# NAND Bus Cycle Sequencer

This block turns queued 32-bit command words into raw cycles on an 8-bit NAND flash bus. Software writes each word into a small command queue at offset 0. The sequencer pops words one at a time and runs each as one of four cycles: a command latch, an address latch, a write burst fed from a byte stream, or a read burst that delivers bytes to a byte stream. The byte streams normally connect to a DMA engine.

Every word carries its own flags. One flag holds completion until the flash reports ready. One marks the final cycle of an operation. One requests an interrupt. A sticky status word records command completion, operation end, queue acceptance, queue overflow and write-stream starvation. Software clears each status bit by writing a one to its position at offset 0x120. The interrupt line is raised only by status bits that a word with the interrupt flag produced.

Top module: `nand_cycle_seq`

## Requirements
- R1: Command word bits 17:16 select the cycle: 0 address (ALE high), 1 command (CLE high), 2 data write, 3 data read. For address and command cycles the flash captures bits 7:0 from the I/O bus on the rising edge of WE#. CLE and ALE are never both high.
- R2: Each WE# or RE# strobe is low for exactly 2 clocks and then high for at least 2 clocks. CLE and ALE take their value one clock before WE# falls and hold it until WE# has risen.
- R3: A data write of length N (bits 11:0 hold N-1) takes N bytes from the transmit stream in arrival order. It gives each byte its own WE# strobe with CLE and ALE low.
- R4: A data read of length N gives N RE# strobes. It samples the I/O bus while RE# is low and offers each byte on the receive stream in order. While the sink is not ready, rxValid stays high with rxData unchanged, and no further RE# strobe starts.
- R5: With bit 19 set, the word does not complete while R/B# is low after its cycle. It completes once R/B# is high.
- R6: Status bit 9 is set when a word completes. Status bit 12 is set as well when that word had bit 18 set.
- R7: Writing a word at offset 0x120 clears every status bit at a position where the written data holds a one, and leaves the others. Status bits 0 and 2 to 8 always read 0.
- R8: The command queue holds 4 words and runs them in write order. A write at offset 0 while 4 words wait sets status bit 11 and drops the word. Bit 11 stays set until it is cleared.
- R9: Status bit 10 is set when the queue accepts a word.
- R10: When a write cycle needs a byte and the transmit stream has none, status bit 1 is set. No WE# strobe starts until a byte arrives.
- R11: irq is high exactly while some set status bit was raised by a word with bit 13 set. A word without bit 13 does not raise irq.
- R12: After reset, WE# and RE# are high, CLE and ALE are low, the I/O bus is not driven, all status bits are 0 and irq is 0.
- R13: The I/O output enable is high only during address, command and write strobes, and never while RE# is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Register write data |
| intStatus | output | 13 | Sticky status bits |
| irq | output | 1 | Interrupt request |
| txData | input | 8 | Transmit stream byte |
| txValid | input | 1 | Transmit byte available |
| txReady | output | 1 | Transmit byte taken |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | Received byte available |
| rxReady | input | 1 | Receive sink ready |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandIoOut | output | 8 | I/O bus output value |
| nandIoOe | output | 1 | I/O bus output enable |
| nandIoIn | input | 8 | I/O bus input value |
| nandRbN | input | 1 | Ready/busy, low while busy |

## Verification
The bench builds the block with its defaults: a 4-word queue, a 12-bit length field and a 12-bit register offset. The shallow queue lets a single command held by a busy R/B# plus four more writes reach the overflow case, and shows that only the dropped fifth word is lost. Short bursts of two and three bytes exercise transmit starvation and receive back-pressure in the middle of an operation, while the full 12-bit length decode stays in place.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    CY_ADDR = 2'd0,
    CY_CMD  = 2'd1,
    CY_WR   = 2'd2,
    CY_RD   = 2'd3
  } cycKind_t;

  // command word field positions
  localparam int KIND_LO  = 16;
  localparam int WFR_BIT  = 19;
  localparam int LAST_BIT = 18;
  localparam int IWC_BIT  = 13;

  // status bit positions
  localparam int STAT_W      = 13;
  localparam int ST_TXUNDER  = 1;
  localparam int ST_CMDDONE  = 9;
  localparam int ST_CMDAVAIL = 10;
  localparam int ST_CMDERR   = 11;
  localparam int ST_XFEROVER = 12;

  typedef struct packed {
    cycKind_t kind;
    logic     wfr;
    logic     last;
    logic     iwc;
  } cmdFlags_t;

  // strobes from control to datapath
  typedef struct packed {
    logic pop;
    logic loadTx;
    logic grabRx;
    logic doneEvt;
    logic lastEvt;
    logic underEvt;
    logic iwc;
  } ctrlStrobe_t;

endpackage

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int LEN_W  = 12,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] FIFO_OFS = 'h000,
  parameter logic [ADDR_W-1:0] CLR_OFS  = 'h120
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic [7:0]        txData,
  input  logic [7:0]        nandIoIn,
  input  ctrlStrobe_t       stb,
  output cmdFlags_t         headFlags,
  output logic [LEN_W-1:0]  headLen,
  output logic              fifoEmpty,
  output logic [7:0]        ioByte,
  output logic [7:0]        rxByte,
  output logic [STAT_W-1:0] status,
  output logic              irq
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  cmdFlags_t        flagMem [DEPTH];
  logic [LEN_W-1:0] lenMem  [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             pushReq, push, fifoFull, errEvt;
  cmdFlags_t        inFlags;

  assign fifoFull  = (count == FULL_CNT);
  assign fifoEmpty = (count == '0);
  assign pushReq   = regWrEn && (regAddr == FIFO_OFS);
  assign push      = pushReq && !fifoFull;
  assign errEvt    = pushReq && fifoFull;

  assign inFlags.kind = cycKind_t'(regWrData[KIND_LO+1:KIND_LO]);
  assign inFlags.wfr  = regWrData[WFR_BIT];
  assign inFlags.last = regWrData[LAST_BIT];
  assign inFlags.iwc  = regWrData[IWC_BIT];

  assign headFlags = flagMem[rdPtr];
  assign headLen   = lenMem[rdPtr];

  // queue storage, no reset needed on contents
  always_ff @(posedge clk) begin
    if (push) begin
      flagMem[wrPtr] <= inFlags;
      lenMem[wrPtr]  <= regWrData[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (stb.pop) rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({push, stb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // byte registers toward the flash and the receive stream
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioByte <= '0;
      rxByte <= '0;
    end else begin
      if (stb.pop)         ioByte <= headLen[7:0];
      else if (stb.loadTx) ioByte <= txData;
      if (stb.grabRx)      rxByte <= nandIoIn;
    end
  end

  // status with write-one-to-clear; a set in the same cycle wins
  logic [STAT_W-1:0] setVec, wordSet, clrVec, irqSrc;

  always_comb begin
    wordSet = '0;
    wordSet[ST_TXUNDER]  = stb.underEvt;
    wordSet[ST_CMDDONE]  = stb.doneEvt;
    wordSet[ST_XFEROVER] = stb.lastEvt;
    setVec = wordSet;
    setVec[ST_CMDAVAIL] = push;
    setVec[ST_CMDERR]   = errEvt;
    clrVec = (regWrEn && (regAddr == CLR_OFS)) ? regWrData[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= '0;
      irqSrc <= '0;
    end else begin
      status <= (status & ~clrVec) | setVec;
      irqSrc <= (irqSrc & ~clrVec) | (wordSet & {STAT_W{stb.iwc}});
    end
  end

  assign irq = |(status & irqSrc);

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEmpty,
  input  cmdFlags_t        headFlags,
  input  logic [LEN_W-1:0] headLen,
  input  logic             txValid,
  input  logic             rxReady,
  input  logic             nandRbN,
  output ctrlStrobe_t      stb,
  output logic             txReady,
  output logic             rxValid,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWeN,
  output logic             nandReN,
  output logic             nandIoOe
);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_LOW, S_HIGH, S_FETCH, S_PUSH, S_FIN
  } seqState_t;

  seqState_t        state;
  logic             ph;
  cmdFlags_t        cur;
  logic [LEN_W-1:0] remain;
  logic             latchPhase, isRead, moreBytes, readyOk;

  assign latchPhase = (state == S_SETUP) || (state == S_LOW) || (state == S_HIGH);
  assign isRead     = (cur.kind == CY_RD);
  assign moreBytes  = (remain != '0);
  assign readyOk    = !cur.wfr || nandRbN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      ph     <= 1'b0;
      cur    <= '{kind: CY_ADDR, wfr: 1'b0, last: 1'b0, iwc: 1'b0};
      remain <= '0;
    end else begin
      case (state)
        S_IDLE: if (!fifoEmpty) begin
          cur    <= headFlags;
          remain <= headLen;
          ph     <= 1'b0;
          case (headFlags.kind)
            CY_WR:   state <= S_FETCH;
            CY_RD:   state <= S_LOW;
            default: state <= S_SETUP;
          endcase
        end
        S_SETUP: state <= S_LOW;
        S_LOW: begin
          ph <= !ph;
          if (ph) state <= S_HIGH;
        end
        S_HIGH: begin
          ph <= !ph;
          if (ph) begin
            if (isRead) state <= S_PUSH;
            else if (cur.kind == CY_WR && moreBytes) begin
              remain <= remain - 1'b1;
              state  <= S_FETCH;
            end else state <= S_FIN;
          end
        end
        S_FETCH: if (txValid) state <= S_LOW;
        S_PUSH: if (rxReady) begin
          if (moreBytes) begin
            remain <= remain - 1'b1;
            state  <= S_LOW;
          end else state <= S_FIN;
        end
        S_FIN: if (readyOk) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // bus pins decoded from the registered state
  assign nandCle  = latchPhase && (cur.kind == CY_CMD);
  assign nandAle  = latchPhase && (cur.kind == CY_ADDR);
  assign nandWeN  = !((state == S_LOW) && !isRead);
  assign nandReN  = !((state == S_LOW) && isRead);
  assign nandIoOe = latchPhase && !isRead;

  assign txReady = (state == S_FETCH);
  assign rxValid = (state == S_PUSH);

  always_comb begin
    stb          = '0;
    stb.pop      = (state == S_IDLE) && !fifoEmpty;
    stb.loadTx   = (state == S_FETCH) && txValid;
    stb.underEvt = (state == S_FETCH) && !txValid;
    stb.grabRx   = (state == S_LOW) && ph && isRead;
    stb.doneEvt  = (state == S_FIN) && readyOk;
    stb.lastEvt  = (state == S_FIN) && readyOk && cur.last;
    stb.iwc      = cur.iwc;
  end

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int LEN_W      = 12,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [12:0]       intStatus,
  output logic              irq,
  input  logic [7:0]        txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [7:0]        rxData,
  output logic              rxValid,
  input  logic              rxReady,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [7:0]        nandIoOut,
  output logic              nandIoOe,
  input  logic [7:0]        nandIoIn,
  input  logic              nandRbN
);

  ctrlStrobe_t      stb;
  cmdFlags_t        headFlags;
  logic [LEN_W-1:0] headLen;
  logic             fifoEmpty;

  nand_seq_dp #(
    .DEPTH (FIFO_DEPTH),
    .LEN_W (LEN_W),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .txData   (txData),
    .nandIoIn (nandIoIn),
    .stb      (stb),
    .headFlags(headFlags),
    .headLen  (headLen),
    .fifoEmpty(fifoEmpty),
    .ioByte   (nandIoOut),
    .rxByte   (rxData),
    .status   (intStatus),
    .irq      (irq)
  );

  nand_seq_ctrl #(
    .LEN_W(LEN_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fifoEmpty(fifoEmpty),
    .headFlags(headFlags),
    .headLen  (headLen),
    .txValid  (txValid),
    .rxReady  (rxReady),
    .nandRbN  (nandRbN),
    .stb      (stb),
    .txReady  (txReady),
    .rxValid  (rxValid),
    .nandCle  (nandCle),
    .nandAle  (nandAle),
    .nandWeN  (nandWeN),
    .nandReN  (nandReN),
    .nandIoOe (nandIoOe)
  );

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic [12:0]       intStatus,
  input logic              irq,
  input logic [7:0]        rxData,
  input logic              rxValid,
  input logic              rxReady,
  input logic              nandCle,
  input logic              nandAle,
  input logic              nandWeN,
  input logic              nandReN,
  input logic              nandIoOe
);

  logic clrErr;
  assign clrErr = regWrEn && (regAddr == ADDR_W'('h120)) && regWrData[11];

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle)); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN)); // R2
  AST_WE_LOW_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nandWeN) |=> !nandWeN); // R2
  AST_WE_LOW_MAX: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN && $past(!nandWeN)) |=> nandWeN); // R2
  AST_WE_HIGH_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |=> nandWeN); // R2
  AST_RE_LOW_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nandReN) |=> !nandReN); // R2
  AST_RE_LOW_MAX: assert property (@(posedge clk) disable iff (!rstN)
    (!nandReN && $past(!nandReN)) |=> nandReN); // R2
  AST_LATCH_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nandWeN) |-> ($stable(nandCle) && $stable(nandAle))); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> ($stable(nandCle) && $stable(nandAle))); // R2
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData))); // R4
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (intStatus[8:2] == '0) && !intStatus[0]); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (intStatus[11] && !clrErr) |=> intStatus[11]); // R8
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (intStatus != '0)); // R11
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandIoOe); // R13

endmodule

bind nand_cycle_seq nand_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .intStatus(intStatus),
  .irq      (irq),
  .rxData   (rxData),
  .rxValid  (rxValid),
  .rxReady  (rxReady),
  .nandCle  (nandCle),
  .nandAle  (nandAle),
  .nandWeN  (nandWeN),
  .nandReN  (nandReN),
  .nandIoOe (nandIoOe)
);

// File: tb/sim_nand_cycle_seq.sv
`timescale 1ns/1ps
module sim_nand_cycle_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [12:0] intStatus;
  logic        irq;
  logic [7:0]  txData;
  logic        txValid;
  logic        txReady;
  logic [7:0]  rxData;
  logic        rxValid;
  logic        rxReady = 1'b1;
  logic        nandCle, nandAle, nandWeN, nandReN, nandIoOe;
  logic [7:0]  nandIoOut;
  logic [7:0]  nandIoIn;
  logic        nandRbN = 1'b1;

  always #2.5 clk = ~clk;

  nand_cycle_seq u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .intStatus(intStatus), .irq(irq),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandIoOut(nandIoOut), .nandIoOe(nandIoOe),
    .nandIoIn(nandIoIn), .nandRbN(nandRbN)
  );

  // stimulus table: command word and expected {CLE,ALE}
  localparam int NVEC = 6;
  localparam logic [31:0] VEC_WORD [NVEC] = '{
    32'h0001_00FF, 32'h0000_0000, 32'h0000_20A5,
    32'h0001_0090, 32'h0004_005A, 32'h0001_2030
  };
  localparam logic [1:0] VEC_KIND [NVEC] = '{
    2'b10, 2'b01, 2'b01, 2'b10, 2'b01, 2'b10
  };

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // flash and stream models
  logic [7:0] txMem [8];
  int         txLen = 0;
  int         txPtr = 0;
  logic       txAvail = 1'b0;
  logic [7:0] devRd [8];
  int         devRdPtr = 0;
  logic [7:0] weByte [64];
  logic [1:0] weKind [64];
  int         weCnt = 0;
  logic [7:0] rxLog [16];
  int         rxCnt = 0;
  int         widthBad = 0;
  int         setupBad = 0;
  int         weRun = 0;
  int         reRun = 0;
  logic       prevWe = 1'b1;
  logic       prevRe = 1'b1;
  logic [1:0] prevLat = 2'b00;

  assign txValid  = txAvail && (txPtr < txLen);
  assign txData   = txMem[txPtr[2:0]];
  assign nandIoIn = devRd[devRdPtr[2:0]];

  always @(posedge clk) begin
    if (!nandWeN) begin
      if (prevWe && ({nandCle, nandAle} != prevLat)) setupBad++;
      weRun++;
    end else if (!prevWe) begin
      if (weRun != 2) widthBad++;
      if (weCnt < 64) begin
        weByte[weCnt] = nandIoOut;
        weKind[weCnt] = {nandCle, nandAle};
      end
      weCnt++;
      weRun = 0;
    end
    if (!nandReN) reRun++;
    else if (!prevRe) begin
      if (reRun != 2) widthBad++;
      reRun = 0;
      devRdPtr <= devRdPtr + 1;
    end
    prevWe  = nandWeN;
    prevRe  = nandReN;
    prevLat = {nandCle, nandAle};
    if (txValid && txReady) txPtr <= txPtr + 1;
    if (rxValid && rxReady && rxCnt < 16) begin
      rxLog[rxCnt] = rxData;
      rxCnt++;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic regWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = '0; regWrData = '0;
  endtask

  task automatic waitBit(input int b, input int lim, output logic ok);
    int n = 0;
    ok = 1'b0;
    while (!ok && n < lim) begin
      @(negedge clk);
      ok = intStatus[b];
      n++;
    end
  endtask

  task automatic clearAll;
    regWr(12'h120, 32'h0000_1FFF);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ok;
    int n;
    repeat (4) @(negedge clk);
    // R12 reset state
    check("R12", "status in reset", {19'd0, intStatus}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R12", "status", {19'd0, intStatus}, 32'd0);
    check("R12", "irq", {31'd0, irq}, 32'd0);
    check("R12", "WE#/RE#/CLE/ALE/OE",
          {27'd0, nandWeN, nandReN, nandCle, nandAle, nandIoOe}, 32'b11000);

    // R1 R6 R9 R11 latch cycles from the table
    for (int i = 0; i < NVEC; i++) begin
      n = weCnt;
      regWr(12'h000, VEC_WORD[i]);
      waitBit(9, 60, ok);
      check("R6", "command done", {31'd0, ok}, 32'd1);
      check("R1", "strobe count", weCnt, n + 1);
      check("R1", "latched byte", {24'd0, weByte[n]}, {24'd0, VEC_WORD[i][7:0]});
      check("R1", "CLE/ALE kind", {30'd0, weKind[n]}, {30'd0, VEC_KIND[i]});
      check("R9", "command available", {31'd0, intStatus[10]}, 32'd1);
      check("R6", "transfer over", {31'd0, intStatus[12]}, {31'd0, VEC_WORD[i][18]});
      check("R11", "irq after word", {31'd0, irq}, {31'd0, VEC_WORD[i][13]});
      clearAll();
      check("R11", "irq after clear", {31'd0, irq}, 32'd0);
    end

    // R3 write burst of 3
    txMem[0] = 8'h11; txMem[1] = 8'h22; txMem[2] = 8'h33;
    txPtr = 0; txLen = 3; txAvail = 1'b1;
    n = weCnt;
    regWr(12'h000, 32'h0002_0002);
    waitBit(9, 100, ok);
    check("R3", "write done", {31'd0, ok}, 32'd1);
    check("R3", "write strobes", weCnt, n + 3);
    for (int k = 0; k < 3; k++) begin
      check("R3", "write byte", {24'd0, weByte[n+k]}, {24'd0, txMem[k]});
      check("R3", "write CLE/ALE low", {30'd0, weKind[n+k]}, 32'd0);
    end
    check("R10", "no underflow when fed", {31'd0, intStatus[1]}, 32'd0);
    clearAll();

    // R10 write stalls on empty stream
    txMem[0] = 8'h44; txMem[1] = 8'h55;
    txPtr = 0; txLen = 2; txAvail = 1'b0;
    n = weCnt;
    regWr(12'h000, 32'h0002_0001);
    repeat (20) @(negedge clk);
    check("R10", "underflow flag", {31'd0, intStatus[1]}, 32'd1);
    check("R10", "no strobe while starved", weCnt, n);
    check("R10", "not done while starved", {31'd0, intStatus[9]}, 32'd0);
    txAvail = 1'b1;
    waitBit(9, 100, ok);
    check("R10", "done after refill", {31'd0, ok}, 32'd1);
    check("R10", "strobes after refill", weCnt, n + 2);
    check("R10", "first byte", {24'd0, weByte[n]}, 32'h44);
    check("R10", "second byte", {24'd0, weByte[n+1]}, 32'h55);
    clearAll();

    // R4 read burst with back-pressure
    devRd[0] = 8'h5A; devRd[1] = 8'hA5; devRd[2] = 8'h3C;
    devRdPtr = 0; rxCnt = 0; rxReady = 1'b0;
    regWr(12'h000, 32'h0003_0002);
    repeat (15) @(negedge clk);
    check("R4", "rxValid held", {31'd0, rxValid}, 32'd1);
    check("R4", "rxData held", {24'd0, rxData}, 32'h5A);
    check("R4", "single RE# strobe while stalled", devRdPtr, 1);
    check("R13", "bus released on read", {31'd0, nandIoOe}, 32'd0);
    rxReady = 1'b1;
    waitBit(9, 100, ok);
    check("R4", "read done", {31'd0, ok}, 32'd1);
    check("R4", "bytes received", rxCnt, 3);
    for (int k = 0; k < 3; k++)
      check("R4", "read byte", {24'd0, rxLog[k]}, {24'd0, devRd[k]});
    clearAll();

    // R5 wait for ready
    nandRbN = 1'b0;
    n = weCnt;
    regWr(12'h000, 32'h0009_0070);
    repeat (30) @(negedge clk);
    check("R5", "strobe issued", weCnt, n + 1);
    check("R5", "held while busy", {31'd0, intStatus[9]}, 32'd0);
    nandRbN = 1'b1;
    waitBit(9, 5, ok);
    check("R5", "done once ready", {31'd0, ok}, 32'd1);
    clearAll();

    // R8 queue overflow behind a busy command
    nandRbN = 1'b0;
    n = weCnt;
    regWr(12'h000, 32'h0009_00E0);
    repeat (5) @(negedge clk);
    for (int k = 0; k < 4; k++) regWr(12'h000, 32'h0001_00C0 + k);
    check("R8", "no error when four queued", {31'd0, intStatus[11]}, 32'd0);
    regWr(12'h000, 32'h0001_00FF);
    check("R8", "error on full write", {31'd0, intStatus[11]}, 32'd1);
    nandRbN = 1'b1;
    repeat (100) @(negedge clk);
    check("R8", "dropped word not run", weCnt, n + 5);
    for (int k = 0; k < 4; k++)
      check("R8", "queue order", {24'd0, weByte[n+1+k]}, 32'hC0 + k);
    check("R8", "error sticky", {31'd0, intStatus[11]}, 32'd1);
    regWr(12'h120, 32'h0000_0800);
    check("R8", "error cleared", {31'd0, intStatus[11]}, 32'd0);
    check("R7", "other bits kept", {31'd0, intStatus[9]}, 32'd1);
    clearAll();
    check("R7", "all cleared", {19'd0, intStatus}, 32'd0);

    // R2 strobe shape seen over the whole run
    check("R2", "strobe width violations", widthBad, 0);
    check("R2", "CLE/ALE setup violations", setupBad, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule